// File: doc/BRIEF.md
# Scatter-Gather Descriptor List Walker

The walker turns a table of fixed-size descriptors held in memory into a stream of (segment address, segment length) pairs for a downstream data mover. Software places the table at a base address and pulses `start`. The walker then reads descriptors one after another. Each descriptor is 8 bytes: a length word at byte offset 0 and an address word at byte offset 4, both 32-bit little-endian words. Entry number i sits at base + 8*i. The walker issues the reads over a simple request/response port that allows one read in flight. It extracts the fields and offers each segment on a valid/ready output.

The walk ends after the segment whose length word carries the terminator flag has been accepted. It also ends when a parameterised number of entries has been consumed without any terminator. In that case the walker reports a missing-terminator error along with the completion pulse. It does not fetch the payload data that the segments describe.

Top module: `sgl_walker`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `err_no_term`, `rd_req_valid` and `seg_valid` are all 0.
- R2: For entry i the walker requests address base + 8*i (the length word) and then base + 8*i + 4 (the address word), in that order. Both reads complete before the segment is offered.
- R3: `seg_len` equals bits [27:0] of the length word. Bits [30:28] of that word have no effect on any output.
- R4: `seg_addr` equals the address word ANDed with 0x7FFFFFFF, so bit 31 of `seg_addr` is always 0.
- R5: Bit 31 of the length word marks the final entry and appears on `seg_last`. Once that segment is accepted, `done` pulses high for exactly one cycle with `err_no_term` = 0, `busy` falls, and no further reads are issued.
- R6: If MAX_ENTRIES segments are accepted and none has bit 31 set, the walk stops after the last of them and `done` pulses with `err_no_term` = 1. Exactly MAX_ENTRIES segments are emitted. A terminator on entry MAX_ENTRIES-1 ends the walk with no error.
- R7: While `seg_valid` is high, no read request is raised. The segment outputs hold steady until `seg_ready` is seen.
- R8: At most one read is outstanding: after a request is accepted, no new request is raised until its response has arrived.
- R9: A `start` pulse while `busy` is high is ignored: the walk in progress keeps its base address and produces a single `done`.
- R10: `err_no_term` rises only together with `done`, holds after the walk, and clears when the next `start` is accepted.
- R11: A read request, once raised, keeps `rd_req_valid` high and `rd_req_addr` unchanged until `rd_req_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk at `base_addr` (accepted only when idle) |
| base_addr | input | AW | Byte address of descriptor 0 |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse when a walk ends |
| err_no_term | output | 1 | Walk ended at the entry cap without a terminator |
| rd_req_valid | output | 1 | Memory read request |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | AW | Byte address of the requested 32-bit word |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 32 | Read data, little-endian word |
| seg_valid | output | 1 | Segment on offer |
| seg_ready | input | 1 | Downstream takes the segment |
| seg_addr | output | AW | Segment start address, bit 31 cleared |
| seg_len | output | 28 | Segment length in bytes |
| seg_last | output | 1 | Segment came from the terminating entry |

## Verification
A corrupted entry index or base register shows up at the ports on the very next read request, as an address that is off the base + 8*i stride. A swapped word select shows as the +4 request coming before the +0 request. Wrong field capture appears on the first offered segment, as a length carrying bits [30:28] or an address with bit 31 set. A broken termination decision shows only when the walk ends, as an extra or missing segment or a wrong error flag beside `done`. For that reason the directed tests cover a terminator on the first entry, a terminator on the capped entry, and no terminator at all.

// File: rtl/sgl_pkg.sv
package sgl_pkg;

  localparam int unsigned WORD_BITS     = 32;
  localparam int unsigned WORD_BYTES    = 4;
  localparam int unsigned DESC_BYTES    = 8;
  localparam int unsigned LAST_FLAG_BIT = 31;
  localparam int unsigned LEN_BITS      = 28;
  localparam int unsigned SEG_ADDR_BITS = 31;

  typedef enum logic [2:0] {
    WK_IDLE     = 3'd0,
    WK_LEN_REQ  = 3'd1,
    WK_LEN_WAIT = 3'd2,
    WK_ADR_REQ  = 3'd3,
    WK_ADR_WAIT = 3'd4,
    WK_EMIT     = 3'd5
  } walk_state_e;

endpackage

// File: rtl/sgl_addr_gen.sv
module sgl_addr_gen #(
  parameter int unsigned AW          = 32,
  parameter int unsigned MAX_ENTRIES = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] base_in,
  input  logic          advance,
  input  logic          hi_word,
  output logic [AW-1:0] req_addr,
  output logic          at_cap
);
  import sgl_pkg::*;

  localparam int unsigned IDX_W      = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1;
  localparam int unsigned DESC_SHIFT = $clog2(DESC_BYTES);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(MAX_ENTRIES - 1);

  logic [AW-1:0]    base_q;
  logic [IDX_W-1:0] idx_q;
  logic [AW-1:0]    entry_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      idx_q  <= '0;
    end else if (load) begin
      base_q <= base_in;
      idx_q  <= '0;
    end else if (advance) begin
      idx_q  <= idx_q + 1'b1;
    end
  end

  always_comb begin
    entry_off = AW'(idx_q) << DESC_SHIFT;
    req_addr  = base_q + entry_off + (hi_word ? AW'(WORD_BYTES) : AW'(0));
    at_cap    = (idx_q == IDX_LAST);
  end

  // R6: the controller never steps past the final permitted entry
  p_adv_below_cap_r6: assert property (@(posedge clk) disable iff (rst)
    advance |-> (idx_q != IDX_LAST));

endmodule

// File: rtl/sgl_len_capture.sv
module sgl_len_capture (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cap_en,
  input  logic [sgl_pkg::WORD_BITS-1:0] word_in,
  output logic [sgl_pkg::LEN_BITS-1:0]  len_o,
  output logic                          last_o
);
  import sgl_pkg::*;

  localparam int unsigned GAP_LO = LEN_BITS;
  localparam int unsigned GAP_HI = LAST_FLAG_BIT - 1;

  logic [GAP_HI:GAP_LO] unused_gap;

  assign unused_gap = word_in[GAP_HI:GAP_LO];

  always_ff @(posedge clk) begin
    if (rst) begin
      len_o  <= '0;
      last_o <= 1'b0;
    end else if (cap_en) begin
      len_o  <= word_in[LEN_BITS-1:0];
      last_o <= word_in[LAST_FLAG_BIT];
    end
  end

endmodule

// File: rtl/sgl_seg_out.sv
module sgl_seg_out #(
  parameter int unsigned AW = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          load,
  input  logic [sgl_pkg::WORD_BITS-1:0] addr_word,
  input  logic [sgl_pkg::LEN_BITS-1:0]  len_in,
  input  logic                          last_in,
  input  logic                          seg_ready,
  output logic                          seg_valid,
  output logic [AW-1:0]                 seg_addr,
  output logic [sgl_pkg::LEN_BITS-1:0]  seg_len,
  output logic                          seg_last,
  output logic                          accept
);
  import sgl_pkg::*;

  localparam logic [WORD_BITS-1:0] ADDR_KEEP =
    WORD_BITS'((64'd1 << SEG_ADDR_BITS) - 64'd1);

  logic [WORD_BITS-1:0] masked;

  assign masked = addr_word & ADDR_KEEP;
  assign accept = seg_valid & seg_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_valid <= 1'b0;
      seg_addr  <= '0;
      seg_len   <= '0;
      seg_last  <= 1'b0;
    end else if (load) begin
      seg_valid <= 1'b1;
      seg_addr  <= AW'(masked);
      seg_len   <= len_in;
      seg_last  <= last_in;
    end else if (accept) begin
      seg_valid <= 1'b0;
    end
  end

  // R7: an offered segment is held until taken
  p_seg_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_addr)
                                   && $stable(seg_len) && $stable(seg_last)));

endmodule

// File: rtl/sgl_walker.sv
module sgl_walker #(
  parameter int unsigned AW          = 32,
  parameter int unsigned MAX_ENTRIES = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic [AW-1:0]                 base_addr,
  output logic                          busy,
  output logic                          done,
  output logic                          err_no_term,
  output logic                          rd_req_valid,
  input  logic                          rd_req_ready,
  output logic [AW-1:0]                 rd_req_addr,
  input  logic                          rd_rsp_valid,
  input  logic [sgl_pkg::WORD_BITS-1:0] rd_rsp_data,
  output logic                          seg_valid,
  input  logic                          seg_ready,
  output logic [AW-1:0]                 seg_addr,
  output logic [sgl_pkg::LEN_BITS-1:0]  seg_len,
  output logic                          seg_last
);
  import sgl_pkg::*;

  walk_state_e         st_q;
  logic                go;
  logic                step;
  logic                at_cap;
  logic                len_cap;
  logic                seg_load;
  logic                seg_take;
  logic [LEN_BITS-1:0] hold_len;
  logic                hold_last;

  always_comb begin
    go       = (st_q == WK_IDLE) && start;
    len_cap  = (st_q == WK_LEN_WAIT) && rd_rsp_valid;
    seg_load = (st_q == WK_ADR_WAIT) && rd_rsp_valid;
    step     = (st_q == WK_EMIT) && seg_take && !seg_last && !at_cap;
    rd_req_valid = (st_q == WK_LEN_REQ) || (st_q == WK_ADR_REQ);
    busy     = (st_q != WK_IDLE);
  end

  sgl_addr_gen #(.AW(AW), .MAX_ENTRIES(MAX_ENTRIES)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .load     (go),
    .base_in  (base_addr),
    .advance  (step),
    .hi_word  (st_q == WK_ADR_REQ),
    .req_addr (rd_req_addr),
    .at_cap   (at_cap)
  );

  sgl_len_capture u_len (
    .clk     (clk),
    .rst     (rst),
    .cap_en  (len_cap),
    .word_in (rd_rsp_data),
    .len_o   (hold_len),
    .last_o  (hold_last)
  );

  sgl_seg_out #(.AW(AW)) u_seg (
    .clk       (clk),
    .rst       (rst),
    .load      (seg_load),
    .addr_word (rd_rsp_data),
    .len_in    (hold_len),
    .last_in   (hold_last),
    .seg_ready (seg_ready),
    .seg_valid (seg_valid),
    .seg_addr  (seg_addr),
    .seg_len   (seg_len),
    .seg_last  (seg_last),
    .accept    (seg_take)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= WK_IDLE;
      done        <= 1'b0;
      err_no_term <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        WK_IDLE: begin
          if (start) begin
            st_q        <= WK_LEN_REQ;
            err_no_term <= 1'b0;
          end
        end
        WK_LEN_REQ:  if (rd_req_ready) st_q <= WK_LEN_WAIT;
        WK_LEN_WAIT: if (rd_rsp_valid) st_q <= WK_ADR_REQ;
        WK_ADR_REQ:  if (rd_req_ready) st_q <= WK_ADR_WAIT;
        WK_ADR_WAIT: if (rd_rsp_valid) st_q <= WK_EMIT;
        WK_EMIT: begin
          if (seg_take) begin
            if (seg_last) begin
              st_q <= WK_IDLE;
              done <= 1'b1;
            end else if (at_cap) begin
              st_q        <= WK_IDLE;
              done        <= 1'b1;
              err_no_term <= 1'b1;
            end else begin
              st_q <= WK_LEN_REQ;
            end
          end
        end
        default: st_q <= WK_IDLE;
      endcase
    end
  end

  // R7: no descriptor fetch while a segment waits downstream
  p_no_fetch_during_seg_r7: assert property (@(posedge clk) disable iff (rst)
    seg_valid |-> !rd_req_valid);

  // R11: a raised request stays put until accepted
  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

  // R8: one read in flight at a time
  p_one_outstanding_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_req_valid && rd_req_ready) |=> !rd_req_valid);

  // R5: completion is a single-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: the error flag only rises alongside completion
  p_err_with_done_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(err_no_term) |-> done);

endmodule

// File: tb/sim_sgl_walker.sv
module sim_sgl_walker;
  localparam int CLK_PERIOD = 10;
  localparam int MAXE       = 6;
  localparam int AW         = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic          busy, done, err_no_term;
  logic          rd_req_valid;
  logic          rd_req_ready = 1'b0;
  logic [AW-1:0] rd_req_addr;
  logic          rd_rsp_valid = 1'b0;
  logic [31:0]   rd_rsp_data = 32'hDEAD_BEEF;
  logic          seg_valid;
  logic          seg_ready = 1'b0;
  logic [AW-1:0] seg_addr;
  logic [27:0]   seg_len;
  logic          seg_last;

  sgl_walker #(.AW(AW), .MAX_ENTRIES(MAXE)) u0 (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
    .busy(busy), .done(done), .err_no_term(err_no_term),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_data(rd_rsp_data), .seg_valid(seg_valid), .seg_ready(seg_ready),
    .seg_addr(seg_addr), .seg_len(seg_len), .seg_last(seg_last)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0;
  int fails = 0;

  logic [31:0] mem [0:255];

  logic [31:0] req_log [0:63];
  int          req_n;
  logic [31:0] sa_log [0:31];
  logic [27:0] sl_log [0:31];
  logic        sf_log [0:31];
  int          seg_n;
  int          done_n;
  logic        done_err;
  int          v7, v8;
  int          hold_cyc;
  int          wait_cnt;
  bit          req_stall;
  bit          pend;
  logic [31:0] pend_addr;
  bit          outstanding;
  int          cyc = 0;

  logic [31:0] exp_len_w [0:31];
  logic [31:0] exp_adr_w [0:31];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // environment: memory responder, segment sink, monitors
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++;
        tests++;
        $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
      rd_rsp_valid = 1'b0;
      rd_rsp_data  = 32'hDEAD_BEEF;
      if (pend) begin
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = mem[pend_addr[9:2]];
        pend = 1'b0;
        outstanding = 1'b0;
      end
      rd_req_ready = req_stall ? (cyc % 3 == 0) : 1'b1;
      if (rd_req_valid && outstanding) v8++;
      if (rd_req_valid && rd_req_ready) begin
        if (req_n < 64) req_log[req_n] = rd_req_addr;
        req_n++;
        pend = 1'b1;
        pend_addr = rd_req_addr;
        outstanding = 1'b1;
      end
      if (seg_valid && rd_req_valid) v7++;
      if (seg_valid) begin
        seg_ready = (wait_cnt >= hold_cyc);
        if (!seg_ready) wait_cnt++;
      end else begin
        seg_ready = 1'b0;
      end
      if (seg_valid && seg_ready) begin
        if (seg_n < 32) begin
          sa_log[seg_n] = seg_addr;
          sl_log[seg_n] = seg_len;
          sf_log[seg_n] = seg_last;
        end
        seg_n++;
        wait_cnt = 0;
      end
      if (done) begin
        done_n++;
        done_err = err_no_term;
      end
    end
  end

  task automatic clear_logs();
    req_n = 0; seg_n = 0; done_n = 0; done_err = 1'b0;
    v7 = 0; v8 = 0; wait_cnt = 0;
  endtask

  task automatic put_desc(input logic [31:0] base, input int i,
                          input logic [31:0] lw, input logic [31:0] aw);
    logic [31:0] a;
    a = base + 32'(8 * i);
    mem[a[9:2]]       = lw;
    mem[a[9:2] + 8'd1] = aw;
    exp_len_w[i] = lw;
    exp_adr_w[i] = aw;
  endtask

  task automatic kick(input logic [31:0] base);
    @(negedge clk);
    base_addr = base;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int n;
    n = 0;
    while (done_n == 0 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(done_n != 0, {tag, " done seen"}, 32'(done_n), 32'd1);
  endtask

  task automatic check_walk(input string tag, input logic [31:0] base,
                            input int n_exp, input bit err_exp);
    chk(seg_n == n_exp, {tag, " R5/R6 segment count"}, 32'(seg_n), 32'(n_exp));
    chk(req_n == 2 * n_exp, {tag, " R2 request count"}, 32'(req_n), 32'(2 * n_exp));
    for (int i = 0; i < n_exp && i < 32; i++) begin
      chk(req_log[2*i] == base + 32'(8*i), {tag, " R2 length word address"},
          req_log[2*i], base + 32'(8*i));
      chk(req_log[2*i+1] == base + 32'(8*i + 4), {tag, " R2 address word address"},
          req_log[2*i+1], base + 32'(8*i + 4));
      chk(sl_log[i] == exp_len_w[i][27:0], {tag, " R3 seg_len"},
          32'(sl_log[i]), 32'(exp_len_w[i][27:0]));
      chk(sa_log[i] == (exp_adr_w[i] & 32'h7FFF_FFFF), {tag, " R4 seg_addr"},
          sa_log[i], exp_adr_w[i] & 32'h7FFF_FFFF);
      chk(sf_log[i] == exp_len_w[i][31], {tag, " R5 seg_last"},
          32'(sf_log[i]), 32'(exp_len_w[i][31]));
    end
    chk(done_err == err_exp, {tag, " R6/R10 error at done"},
        32'(done_err), 32'(err_exp));
    chk(v7 == 0, {tag, " R7 fetch during pending segment"}, 32'(v7), 32'd0);
    chk(v8 == 0, {tag, " R8 second read in flight"}, 32'(v8), 32'd0);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !err_no_term && !rd_req_valid && !seg_valid,
        "R1 reset outputs", {27'd0, busy, done, err_no_term, rd_req_valid, seg_valid},
        32'd0);
  endtask

  task automatic t_single();
    clear_logs(); hold_cyc = 0; req_stall = 1'b0;
    put_desc(32'h40, 0, 32'hF000_0123, 32'hFFFF_FFF0);
    kick(32'h40);
    wait_done("single");
    repeat (6) @(negedge clk);
    check_walk("single", 32'h40, 1, 1'b0);
    chk(done_n == 1, "R5 single done pulse count", 32'(done_n), 32'd1);
    chk(!busy && req_n == 2, "R5 idle after terminator", {31'd0, busy}, 32'd0);
  endtask

  task automatic t_multi();
    clear_logs(); hold_cyc = 3; req_stall = 1'b1;
    put_desc(32'h100, 0, 32'h0000_0010, 32'h8000_1000);
    put_desc(32'h100, 1, 32'h7FFF_FFFF, 32'h1234_5678);
    put_desc(32'h100, 2, 32'h8000_0004, 32'hC000_0003);
    kick(32'h100);
    wait_done("multi");
    repeat (4) @(negedge clk);
    check_walk("multi", 32'h100, 3, 1'b0);
  endtask

  task automatic t_cap();
    clear_logs(); hold_cyc = 1; req_stall = 1'b0;
    for (int i = 0; i < MAXE; i++)
      put_desc(32'h200, i, 32'h0000_0100 + 32'(i), 32'h0010_0000 + 32'(i * 64));
    put_desc(32'h200, MAXE, 32'h8000_0099, 32'h0000_0099);
    kick(32'h200);
    wait_done("cap");
    repeat (8) @(negedge clk);
    check_walk("cap", 32'h200, MAXE, 1'b1);
    chk(err_no_term == 1'b1, "R10 error held after walk", {31'd0, err_no_term}, 32'd1);
  endtask

  task automatic t_last_at_cap();
    clear_logs(); hold_cyc = 0; req_stall = 1'b1;
    for (int i = 0; i < MAXE - 1; i++)
      put_desc(32'h300, i, 32'h0000_0020, 32'h0000_0400 + 32'(i));
    put_desc(32'h300, MAXE - 1, 32'h8000_0021, 32'h0000_0500);
    @(negedge clk);
    base_addr = 32'h300;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err_no_term == 1'b0, "R10 error cleared by start", {31'd0, err_no_term}, 32'd0);
    wait_done("lastcap");
    repeat (4) @(negedge clk);
    check_walk("lastcap", 32'h300, MAXE, 1'b0);
  endtask

  task automatic t_busy_start();
    clear_logs(); hold_cyc = 5; req_stall = 1'b0;
    put_desc(32'h380, 0, 32'h0000_0040, 32'h0000_8000);
    put_desc(32'h380, 1, 32'h8000_0041, 32'h0000_9000);
    mem[8'h10] = 32'h8000_0777;
    mem[8'h11] = 32'h0000_0777;
    kick(32'h380);
    repeat (4) @(negedge clk);
    base_addr = 32'h40;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("busystart");
    repeat (20) @(negedge clk);
    check_walk("busystart", 32'h380, 2, 1'b0);
    chk(done_n == 1, "R9 single done despite extra start", 32'(done_n), 32'd1);
  endtask

  initial begin
    pend = 1'b0; outstanding = 1'b0; hold_cyc = 0; req_stall = 1'b0;
    clear_logs();
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_cap();
    t_last_at_cap();
    t_busy_start();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule